// File: doc/BRIEF.md
# SDRAM Column Burst Engine

This block models the column-access half of a synchronous DRAM device. A registered command selects a read, a write or a mode load. Reads and writes carry a starting column. The engine walks the burst through the columns in sequential or interleaved order, wrapping inside the aligned group of the burst length. It captures write data, or presents read data after the programmed CAS latency. A small register array stands in for the storage cells. The data bus is split into an input, an output and an output enable, the usual arrangement inside a chip in front of a bidirectional pad.

A clock-enable input can freeze the internal clock in the middle of an access. While frozen, the burst counter, the latency pipeline and the data-mask pipeline all hold. Commands and write data are ignored, and read data already on the bus stays driven. A mode bit can turn every write into a single-column access while reads keep the programmed burst length.

Top module: `sdram_col_burst`

## Requirements
- R1: After reset, `dq_oe` is 0. The mode is burst length 1, sequential order, CAS latency 2, and normal write bursts.
- R2: On a mode command (`cmd`=3) the engine loads its mode from `addr`, and any burst in progress ends:
  - `addr[1:0]` gives the burst length (0→1, 1→2, 2→4, 3→8).
  - `addr[3]`=1 selects interleaved order.
  - `addr[4]`=1 selects CAS latency 3, and 0 selects latency 2.
  - `addr[9]`=1 selects single-column writes.
- R3: A read (`cmd`=1) at an active edge T drives its first word on `dq_o`, with `dq_oe`=1, so that it can be sampled at edge T+CL. Each following word comes one active edge later.
- R4: Beat i of a burst of length L from column b uses the column `(b & ~(L-1)) | ((b+i) & (L-1))` in sequential order, and `(b & ~(L-1)) | ((b^i) & (L-1))` in interleaved order.
- R5: A write (`cmd`=2) stores `dq_i` at the command edge and at each following active edge of the burst.
- R6: With single-column writes selected, a write stores only the word at its command edge, while reads still run the full programmed length and order.
- R7: When `cke` is sampled low at edge k, edge k+1 is suspended. The burst column counter does not advance on a suspended edge. Operation resumes on the edge after the one where `cke` is sampled high.
- R8: A command, a `dqm` value and write data present at a suspended edge are ignored.
- R9: Across suspended edges, `dq_o` and `dq_oe` hold their values. The latency pipeline also holds, so read data resumes in order.
- R10: If `dqm` is high on an active write beat, that beat leaves its column unchanged.
- R11: If `dqm` is high at active edge T, `dq_oe` is 0 after the following active edge, for one active cycle.
- R12: A read or write at an active edge ends the current burst and starts the new access at its own column.
- R13: A write command drops all read data still in the latency pipeline, so `dq_oe` is 0 after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low suspends the next internal edge |
| cmd | input | 2 | 0 idle, 1 read, 2 write, 3 mode load |
| addr | input | ADDR_W | Start column in the low bits, or the mode word |
| dqm | input | 1 | Data mask for write beats and read output |
| dq_i | input | DATA_W | Write data from the bus |
| dq_o | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Drive enable for read data |

## Verification
A column generator that is off by one shows up as the wrong word on `dq_o`. A counter that runs on through a suspension does the same, and both appear CL edges after the faulty beat. A suspension that leaks into the latency or mask pipelines shows as output that changes while `cke` is low, or as data that resumes out of order on the first active edge afterwards. A write that lands on the wrong column, or escapes its mask, only shows when that column is read back. For that reason every write is later covered by reads, and the bench keeps a model of the storage cells.

// File: rtl/sdram_col_burst.sv
module sdram_col_burst #(
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dqm,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  localparam int DEPTH = 1 << COL_W;
  localparam int PIPE  = 3;
  localparam int M_ILV = 3;
  localparam int M_CL  = 4;
  localparam int M_SW  = 9;
  localparam logic [1:0] C_NOP = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_MODE = 2'd3;

  logic              en;
  logic [1:0]        bl_code;
  logic              ilv, cl3, single;
  logic              busy, is_wr;
  logic [COL_W-1:0]  base;
  logic [3:0]        cnt, len;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PIPE-1:0]   pv;
  logic [DATA_W-1:0] pd [PIPE];
  logic [1:0]        mq;

  logic              start, act, beat_wr;
  logic [3:0]        bl_len, new_len, beat_len, beat_idx;
  logic [COL_W-1:0]  beat_base, cmask, idx_c, bcol;

  assign start   = en && (cmd == C_RD || cmd == C_WR);
  assign bl_len  = 4'd1 << bl_code;
  assign new_len = (cmd == C_WR && single) ? 4'd1 : bl_len;

  always_comb begin
    beat_base = start ? addr[COL_W-1:0] : base;
    beat_idx  = start ? 4'd0 : cnt;
    beat_len  = start ? new_len : len;
    beat_wr   = start ? (cmd == C_WR) : is_wr;
    act       = start || (en && busy && cmd == C_NOP);
    cmask     = COL_W'(beat_len - 4'd1);
    idx_c     = COL_W'(beat_idx);
    if (ilv) bcol = (beat_base & ~cmask) | ((beat_base ^ idx_c) & cmask);
    else     bcol = (beat_base & ~cmask) | ((beat_base + idx_c) & cmask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b1;
      bl_code <= 2'd0;
      ilv     <= 1'b0;
      cl3     <= 1'b0;
      single  <= 1'b0;
      busy    <= 1'b0;
      is_wr   <= 1'b0;
      base    <= '0;
      cnt     <= 4'd0;
      len     <= 4'd1;
      pv      <= '0;
      mq      <= 2'b00;
      for (int i = 0; i < PIPE; i++) pd[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      en <= cke;
      if (en) begin
        mq <= {mq[0], dqm};
        for (int i = PIPE-1; i > 0; i--) pd[i] <= pd[i-1];
        pd[0] <= mem[bcol];
        if (start && cmd == C_WR) pv <= '0;
        else                      pv <= {pv[PIPE-2:0], act && !beat_wr};
        if (act && beat_wr && !dqm) mem[bcol] <= dq_i;
        if (cmd == C_MODE) begin
          bl_code <= addr[1:0];
          ilv     <= addr[M_ILV];
          cl3     <= addr[M_CL];
          single  <= addr[M_SW];
          busy    <= 1'b0;
        end else if (start) begin
          base  <= addr[COL_W-1:0];
          len   <= new_len;
          is_wr <= (cmd == C_WR);
          cnt   <= 4'd1;
          busy  <= new_len > 4'd1;
        end else if (busy) begin
          cnt  <= cnt + 4'd1;
          busy <= (cnt + 4'd1) < len;
        end
      end
    end
  end

  assign dq_o  = cl3 ? pd[2] : pd[1];
  assign dq_oe = (cl3 ? pv[2] : pv[1]) && !mq[1];

  a_r7_counter_frozen: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt) && $stable(busy) && $stable(base));
  a_r9_output_held: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dq_o) && $stable(dq_oe));
  a_r6_single_write: assert property (@(posedge clk) disable iff (rst)
    en && cmd == C_WR && single |=> !busy);
  a_r13_write_drops_reads: assert property (@(posedge clk) disable iff (rst)
    en && cmd == C_WR |=> !dq_oe);
  a_r11_read_mask: assert property (@(posedge clk) disable iff (rst)
    en && $past(en) && $past(dqm) |=> !dq_oe);
endmodule

// File: tb/test_sdram_col_burst.sv
`timescale 1ns/1ps
module test_sdram_col_burst;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cke = 1'b1;
  logic [1:0] cmd = 2'd0;
  logic [9:0] addr = '0;
  logic       dqm = 1'b0;
  logic [7:0] dq_i = '0;
  logic [7:0] dq_o;
  logic       dq_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdram_col_burst #(.COL_W(4), .DATA_W(8), .ADDR_W(10)) i_sdram_col_burst (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .addr(addr), .dqm(dqm),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe));

  logic [7:0] mm [16];
  bit m_en = 1, m_ilv = 0, m_cl3 = 0, m_single = 0, m_busy = 0, m_wr = 0;
  int m_bl = 0, m_base = 0, m_cnt = 0, m_len = 1;
  bit ev [3];
  logic [7:0] ed [3];
  bit em [2];

  function automatic int colf(int b, int i, int l, bit il);
    int msk = l - 1;
    return il ? ((b & ~msk) | ((b ^ i) & msk)) : ((b & ~msk) | ((b + i) & msk));
  endfunction

  task automatic model(bit k, logic [1:0] c, logic [9:0] a, bit m, logic [7:0] d);
    bit st, ac, wr;
    int b, i, l, col;
    if (m_en) begin
      st = (c == 2'd1 || c == 2'd2);
      ac = 0; wr = 0; b = 0; i = 0; l = 1;
      if (st) begin
        b = int'(a[3:0]); i = 0; wr = (c == 2'd2); ac = 1;
        l = (wr && m_single) ? 1 : (1 << m_bl);
      end else if (m_busy && c == 2'd0) begin
        b = m_base; i = m_cnt; l = m_len; wr = m_wr; ac = 1;
      end
      col = colf(b, i, l, m_ilv) & 15;
      ev[2] = ev[1]; ev[1] = ev[0]; ev[0] = ac && !wr;
      ed[2] = ed[1]; ed[1] = ed[0]; ed[0] = mm[col];
      if (st && wr) begin ev[0] = 0; ev[1] = 0; ev[2] = 0; end
      em[1] = em[0]; em[0] = m;
      if (ac && wr && !m) mm[col] = d;
      if (c == 2'd3) begin
        m_bl = int'(a[1:0]); m_ilv = a[3]; m_cl3 = a[4]; m_single = a[9]; m_busy = 0;
      end else if (st) begin
        m_base = b; m_len = l; m_wr = wr; m_cnt = 1; m_busy = l > 1;
      end else if (m_busy) begin
        m_cnt++; m_busy = m_cnt < m_len;
      end
    end
    m_en = k;
  endtask

  task automatic check(string tag);
    int s = m_cl3 ? 2 : 1;
    bit eoe = ev[s] && !em[1];
    checks++;
    if (dq_oe !== eoe) begin
      errors++;
      $display("FAIL %s dq_oe %0b expected %0b at %0t", tag, dq_oe, eoe, $time);
    end else if (eoe && dq_o !== ed[s]) begin
      errors++;
      $display("FAIL %s dq_o %02h expected %02h at %0t", tag, dq_o, ed[s], $time);
    end
  endtask

  task automatic tick(bit k, logic [1:0] c, logic [9:0] a, bit m, logic [7:0] d, string tag);
    cke = k; cmd = c; addr = a; dqm = m; dq_i = d;
    model(k, c, a, m, d);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) tick(1, 2'd0, '0, 0, 8'h00, tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mm[i] = '0;
    for (int i = 0; i < 3; i++) begin ev[i] = 0; ed[i] = '0; end
    em[0] = 0; em[1] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1");
    tick(1, 2'd1, 10'd3, 0, 0, "R1");
    idle(3, "R1");
    // R2 R5 R4: BL4 sequential CL2, write from column 5
    tick(1, 2'd3, 10'h002, 0, 0, "R2");
    tick(1, 2'd2, 10'd5, 0, 8'h11, "R5");
    tick(1, 2'd0, 0, 0, 8'h22, "R5");
    tick(1, 2'd0, 0, 0, 8'h33, "R5");
    tick(1, 2'd0, 0, 0, 8'h44, "R5");
    tick(1, 2'd1, 10'd6, 0, 0, "R4");
    idle(5, "R3");
    // R4 R3: BL8 interleaved CL3, fill then read
    tick(1, 2'd3, 10'h01B, 0, 0, "R2");
    tick(1, 2'd2, 10'd0, 0, 8'hA0, "R5");
    for (int i = 1; i < 8; i++) tick(1, 2'd0, 0, 0, 8'hA0 + 8'(i), "R5");
    tick(1, 2'd1, 10'd5, 0, 0, "R4");
    idle(10, "R3");
    // R7 R9: suspend in the middle of a read burst
    tick(1, 2'd1, 10'd2, 0, 0, "R7");
    idle(3, "R9");
    tick(0, 2'd0, 0, 0, 0, "R9");
    tick(0, 2'd1, 10'd9, 1, 0, "R8");
    tick(0, 2'd2, 10'd1, 0, 8'hEE, "R8");
    tick(1, 2'd0, 0, 0, 0, "R9");
    idle(9, "R7");
    // R8: write with suspended beats in a BL4 sequential burst
    tick(1, 2'd3, 10'h002, 0, 0, "R2");
    tick(1, 2'd2, 10'd8, 0, 8'h51, "R5");
    tick(0, 2'd0, 0, 0, 8'h52, "R8");
    tick(1, 2'd1, 10'd3, 0, 8'h53, "R8");
    tick(1, 2'd0, 0, 0, 8'h54, "R8");
    tick(1, 2'd0, 0, 0, 8'h55, "R8");
    tick(1, 2'd1, 10'd8, 0, 0, "R8");
    idle(6, "R8");
    // R6: single-column writes, reads keep BL4
    tick(1, 2'd3, 10'h202, 0, 0, "R6");
    tick(1, 2'd2, 10'd12, 0, 8'h61, "R6");
    tick(1, 2'd0, 0, 0, 8'h62, "R6");
    tick(1, 2'd0, 0, 0, 8'h63, "R6");
    tick(1, 2'd1, 10'd12, 0, 0, "R6");
    idle(6, "R6");
    // R10 R11: masks
    tick(1, 2'd3, 10'h002, 0, 0, "R2");
    tick(1, 2'd2, 10'd0, 0, 8'h71, "R10");
    tick(1, 2'd0, 0, 1, 8'h72, "R10");
    tick(1, 2'd0, 0, 0, 8'h73, "R10");
    tick(1, 2'd0, 0, 1, 8'h74, "R10");
    tick(1, 2'd1, 10'd0, 0, 0, "R10");
    tick(1, 2'd0, 0, 1, 0, "R11");
    idle(5, "R11");
    // R12 R13: interruptions
    tick(1, 2'd1, 10'd4, 0, 0, "R12");
    tick(1, 2'd1, 10'd9, 0, 0, "R12");
    tick(1, 2'd0, 0, 0, 0, "R12");
    tick(1, 2'd2, 10'd14, 0, 8'h81, "R13");
    tick(1, 2'd0, 0, 0, 8'h82, "R13");
    tick(1, 2'd1, 10'd14, 0, 0, "R12");
    idle(6, "R12");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom % 16);
      logic [1:0] c = (r < 8) ? 2'd0 : (r < 11) ? 2'd1 : (r < 15) ? 2'd2 : 2'd3;
      logic [9:0] a = 10'($urandom);
      tick(($urandom % 5) != 0, c, a, ($urandom % 7) == 0, 8'($urandom), "R4/R7/R8/R12");
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule